// File: doc/BRIEF.md
# Loopback Test-Mode Controller

This block is the digital control for a sampled serial link between a host-side signal processor and a line-side converter. A small register port holds the test-mode configuration. On every sample-rate strobe the block decides what drives the serial output. It can drive it from an internal filter path that loops the serial input back, or from the most recent sample returned by the line side. While the line side is powered down, the loop through the internal filter is the default. In that state no frames go out and no off-hook request is needed.

Once the line side is powered up, each strobe sends one frame to the line-side partner. The frame carries the input sample and a two-bit mode code that tells the partner how to answer. An off-hook request starts a calibration window of a fixed number of strobes. Test modes written during this window are stored but not applied until the window ends. A link flag reports whether the partner is answering. When more than one test mode is requested at once, the block raises an error flag and falls back to the filter loop, so the result is always defined.

Top module: `lbk_mode_ctrl`

## Requirements
- R1: After reset, register 6 reads 8'h10 (power-down bit 4 set), register 2 reads 8'h02 (hybrid-enable bit 1 set), registers 1 and 5 read zero, status register 12 reads zero, and no frame is sent.
- R2: While power-down is set, no frame is sent (ls_tx_valid stays low). sdo_data equals the sdi_data sample taken FILT_DLY-1 strobes earlier: after strobe k it shows the sample from strobe k-FILT_DLY+1, or zero if fewer than FILT_DLY strobes have occurred since reset.
- R3: With power-down clear, each strobe sends one frame whose data is the sdi_data sample. sdo_data shows the data of the latest returned frame (ls_rx_valid), and holds it while no frame returns.
- R4: link_up (also register 12 bit 6) rises on the clock after a returned frame while power-down is clear. It falls one clock after power-down is set, or on the LINK_TMO-th consecutive strobe with no returned frame.
- R5: Writing 1 to register 5 bit 0 (off-hook) with power-down clear raises cal_busy (register 12 bit 0). cal_busy stays high through CAL_LEN-1 strobes and falls on the CAL_LEN-th. Every frame sent while it is high carries mode code 0.
- R6: After calibration, exactly one requested mode selects the frame mode code: register 1 bit 0 (digital loop) gives 1, register 2 bit 0 (external analog loop) gives 2, register 2 bit 1 cleared (internal analog loop) gives 3. No mode requested gives 0.
- R7: If two or more modes are requested after calibration, mode_err (register 12 bit 1) is high, frames carry code 0, and sdo_data follows the filter path as in R2.
- R8: Register 11 reads 8'h04 (host-side revision 0100) and register 13 reads 8'h01 (line-side revision 0001).
- R9: Writable bits read back as written. Writes to registers 11, 12 and 13 have no effect on their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for write and read |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from reg_addr |
| fs_tick | input | 1 | Sample-rate strobe, one clock wide |
| sdi_data | input | SW | Serial input sample, taken on fs_tick |
| sdo_data | output | SW | Serial output sample |
| ls_tx_valid | output | 1 | Frame to line side valid |
| ls_tx_data | output | SW | Frame sample to line side |
| ls_tx_mode | output | 2 | Frame mode code to line side |
| ls_rx_valid | input | 1 | Returned frame valid |
| ls_rx_data | input | SW | Returned frame sample |
| cal_busy | output | 1 | Calibration window active |
| mode_err | output | 1 | Conflicting test modes requested |
| link_up | output | 1 | Line-side partner answering |

## Verification
A stuck power-down or path-select state shows up on sdo_data within a single strobe. The output then carries the filter-delayed input where the partner's answer was expected, or the reverse, and the bench checks it after every strobe. A calibration counter that stops one strobe early or late shows up as a wrong cal_busy at the exact boundary, or as a nonzero mode code in the first frame after it. A link monitor that is off by one shows up at the second or third unanswered strobe.

// File: rtl/lbk_pkg.sv
`timescale 1ns/1ps
package lbk_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_DIGLB  = 2'd1,
    MD_EXTLB  = 2'd2,
    MD_INTLB  = 2'd3
  } lbk_mode_e;

  typedef struct packed {
    logic dlb;
    logic alb;
    logic hyb;
    logic hook;
    logic pwr;
  } lbk_cfg_t;

  localparam int ADR_DLB  = 1;
  localparam int ADR_ALB  = 2;
  localparam int ADR_HOOK = 5;
  localparam int ADR_PWR  = 6;
  localparam int ADR_REVH = 11;
  localparam int ADR_STAT = 12;
  localparam int ADR_REVL = 13;

  localparam int BIT_DLB   = 0;
  localparam int BIT_ALB   = 0;
  localparam int BIT_HYB   = 1;
  localparam int BIT_HOOK  = 0;
  localparam int BIT_PWR   = 4;
  localparam int STAT_BUSY = 0;
  localparam int STAT_ERR  = 1;
  localparam int STAT_LINK = 6;

  localparam logic [3:0] REV_HOST = 4'b0100;
  localparam logic [3:0] REV_LINE = 4'b0001;

  function automatic int mode_votes(input lbk_cfg_t c);
    int n;
    n = 0;
    if (c.dlb)  n = n + 1;
    if (c.alb)  n = n + 1;
    if (!c.hyb) n = n + 1;
    return n;
  endfunction

  function automatic lbk_mode_e mode_pick(input lbk_cfg_t c);
    if (c.dlb)       return MD_DIGLB;
    else if (c.alb)  return MD_EXTLB;
    else if (!c.hyb) return MD_INTLB;
    else             return MD_NORMAL;
  endfunction

endpackage

// File: rtl/lbk_regs.sv
`timescale 1ns/1ps
module lbk_regs
  import lbk_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          st_busy,
  input  logic          st_err,
  input  logic          st_link,
  output lbk_cfg_t      cfg,
  output logic [DW-1:0] rdata
);

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.dlb  <= 1'b0;
      cfg.alb  <= 1'b0;
      cfg.hyb  <= 1'b1;
      cfg.hook <= 1'b0;
      cfg.pwr  <= 1'b1;
    end else if (wr) begin
      case (addr)
        AW'(ADR_DLB):  cfg.dlb <= wdata[BIT_DLB];
        AW'(ADR_ALB): begin
          cfg.alb <= wdata[BIT_ALB];
          cfg.hyb <= wdata[BIT_HYB];
        end
        AW'(ADR_HOOK): cfg.hook <= wdata[BIT_HOOK];
        AW'(ADR_PWR):  cfg.pwr  <= wdata[BIT_PWR];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(ADR_DLB):  rdata[BIT_DLB] = cfg.dlb;
      AW'(ADR_ALB): begin
        rdata[BIT_ALB] = cfg.alb;
        rdata[BIT_HYB] = cfg.hyb;
      end
      AW'(ADR_HOOK): rdata[BIT_HOOK] = cfg.hook;
      AW'(ADR_PWR):  rdata[BIT_PWR]  = cfg.pwr;
      AW'(ADR_REVH): rdata[3:0] = REV_HOST;
      AW'(ADR_STAT): begin
        rdata[STAT_BUSY] = st_busy;
        rdata[STAT_ERR]  = st_err;
        rdata[STAT_LINK] = st_link;
      end
      AW'(ADR_REVL): rdata[3:0] = REV_LINE;
      default: ;
    endcase
  end

endmodule

// File: rtl/lbk_cal_timer.sv
`timescale 1ns/1ps
module lbk_cal_timer #(
  parameter int CAL_LEN = 4608
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_tick,
  input  logic hook,
  input  logic pwr,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CAL_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (pwr || !hook) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (fs_tick && !done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign busy = hook && !pwr && !done;

endmodule

// File: rtl/lbk_filt_pipe.sv
`timescale 1ns/1ps
module lbk_filt_pipe #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fs_tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stg[i] <= '0;
        else if (fs_tick) stg[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stg[i] <= '0;
        else if (fs_tick) stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];

endmodule

// File: rtl/lbk_link_mon.sv
`timescale 1ns/1ps
module lbk_link_mon #(
  parameter int TMO = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_tick,
  input  logic pwr,
  input  logic rx_valid,
  output logic link
);

  localparam int MW = $clog2(TMO + 1);
  localparam logic [MW-1:0] LIMIT = MW'(TMO - 1);

  logic [MW-1:0] miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss <= '0;
      link <= 1'b0;
    end else if (pwr) begin
      miss <= '0;
      link <= 1'b0;
    end else if (rx_valid) begin
      miss <= '0;
      link <= 1'b1;
    end else if (fs_tick) begin
      if (miss == LIMIT) link <= 1'b0;
      else               miss <= miss + 1'b1;
    end
  end

endmodule

// File: rtl/lbk_mode_ctrl.sv
`timescale 1ns/1ps
module lbk_mode_ctrl
  import lbk_pkg::*;
#(
  parameter int SW       = 16,
  parameter int FILT_DLY = 4,
  parameter int CAL_LEN  = 4608,
  parameter int LINK_TMO = 3,
  parameter int AW       = 4,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          fs_tick,
  input  logic [SW-1:0] sdi_data,
  output logic [SW-1:0] sdo_data,
  output logic          ls_tx_valid,
  output logic [SW-1:0] ls_tx_data,
  output logic [1:0]    ls_tx_mode,
  input  logic          ls_rx_valid,
  input  logic [SW-1:0] ls_rx_data,
  output logic          cal_busy,
  output logic          mode_err,
  output logic          link_up
);

  lbk_cfg_t      cfg;
  logic          pwr_dn;
  logic          cal_done;
  logic          loop_sel;
  lbk_mode_e     mode_apply;
  logic [SW-1:0] filt_out;
  logic [SW-1:0] rx_hold;

  lbk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .st_busy (cal_busy),
    .st_err  (mode_err),
    .st_link (link_up),
    .cfg     (cfg),
    .rdata   (reg_rdata)
  );

  assign pwr_dn = cfg.pwr;

  lbk_cal_timer #(.CAL_LEN(CAL_LEN)) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs_tick (fs_tick),
    .hook    (cfg.hook),
    .pwr     (pwr_dn),
    .busy    (cal_busy),
    .done    (cal_done)
  );

  lbk_filt_pipe #(.W(SW), .DEPTH(FILT_DLY)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs_tick (fs_tick),
    .din     (sdi_data),
    .dout    (filt_out)
  );

  lbk_link_mon #(.TMO(LINK_TMO)) u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_tick  (fs_tick),
    .pwr      (pwr_dn),
    .rx_valid (ls_rx_valid),
    .link     (link_up)
  );

  // Test modes only take effect once calibration has completed.
  assign mode_err   = cal_done && (mode_votes(cfg) > 1);
  assign mode_apply = (cal_done && !mode_err) ? mode_pick(cfg) : MD_NORMAL;
  assign loop_sel   = pwr_dn || mode_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_tx_valid <= 1'b0;
      ls_tx_data  <= '0;
      ls_tx_mode  <= MD_NORMAL;
    end else begin
      ls_tx_valid <= fs_tick && !pwr_dn;
      if (fs_tick && !pwr_dn) begin
        ls_tx_data <= sdi_data;
        ls_tx_mode <= mode_apply;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rx_hold <= '0;
    else if (ls_rx_valid && !pwr_dn) rx_hold <= ls_rx_data;
  end

  assign sdo_data = loop_sel ? filt_out : rx_hold;

endmodule

// File: rtl/lbk_mode_ctrl_chk.sv
`timescale 1ns/1ps
module lbk_mode_ctrl_chk #(
  parameter int SW = 16,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_dn,
  input logic          mode_err,
  input logic          cal_busy,
  input logic          link_up,
  input logic          ls_tx_valid,
  input logic [1:0]    ls_tx_mode,
  input logic          ls_rx_valid,
  input logic [SW-1:0] sdo_data,
  input logic [SW-1:0] filt_out,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata
);

  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn && $past(pwr_dn) |-> !ls_tx_valid); // R2

  AST_LINK_PD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !link_up); // R4

  AST_LINK_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(ls_rx_valid)); // R4

  AST_BUSY_NORMAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ls_tx_valid && $past(cal_busy) |-> ls_tx_mode == 2'd0); // R5

  AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> sdo_data == filt_out); // R7

  AST_ERR_NORMAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ls_tx_valid && $past(mode_err) |-> ls_tx_mode == 2'd0); // R7

  AST_REV_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'(11) |-> reg_rdata == DW'(8'h04)); // R8

  AST_REV_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'(13) |-> reg_rdata == DW'(8'h01)); // R8

endmodule

bind lbk_mode_ctrl lbk_mode_ctrl_chk #(.SW(SW), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_dn      (pwr_dn),
  .mode_err    (mode_err),
  .cal_busy    (cal_busy),
  .link_up     (link_up),
  .ls_tx_valid (ls_tx_valid),
  .ls_tx_mode  (ls_tx_mode),
  .ls_rx_valid (ls_rx_valid),
  .sdo_data    (sdo_data),
  .filt_out    (filt_out),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata)
);

// File: tb/tb_lbk_mode_ctrl.sv
`timescale 1ns/1ps
module tb_lbk_mode_ctrl;

  localparam int SW = 16;
  localparam int D  = 4;
  localparam int CL = 4608;
  localparam int LT = 3;

  typedef struct {
    string       req;
    logic [15:0] exp;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        fs_tick = 1'b0;
  logic [15:0] sdi_data = '0;
  logic [15:0] sdo_data;
  logic        ls_tx_valid;
  logic [15:0] ls_tx_data;
  logic [1:0]  ls_tx_mode;
  logic        ls_rx_valid = 1'b0;
  logic [15:0] ls_rx_data = '0;
  logic        cal_busy, mode_err, link_up;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  sb_item_t    exp_q[$];
  logic [15:0] hist[$];
  logic        m_pwr = 1'b1;
  logic        m_loop = 1'b1;
  logic [1:0]  m_mode = 2'd0;
  logic [15:0] m_rx = '0;
  bit          partner_on = 1;

  always #2.5 clk = ~clk;

  lbk_mode_ctrl #(.SW(SW), .FILT_DLY(D), .CAL_LEN(CL), .LINK_TMO(LT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fs_tick(fs_tick),
    .sdi_data(sdi_data), .sdo_data(sdo_data), .ls_tx_valid(ls_tx_valid),
    .ls_tx_data(ls_tx_data), .ls_tx_mode(ls_tx_mode),
    .ls_rx_valid(ls_rx_valid), .ls_rx_data(ls_rx_data),
    .cal_busy(cal_busy), .mode_err(mode_err), .link_up(link_up)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Partner answer rule per mode code.
  function automatic logic [15:0] partner(input logic [15:0] d, input logic [1:0] m);
    case (m)
      2'd0: return d ^ 16'h00FF;
      2'd1: return d;
      2'd2: return 16'h1234;
      default: return ~d;
    endcase
  endfunction

  function automatic logic [15:0] filt_exp();
    if (hist.size() >= D) return hist[hist.size() - D];
    return 16'h0;
  endfunction

  // Monitor: pops scoreboard items and compares against sdo_data.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        sb_item_t it;
        it = exp_q.pop_front();
        chk(it.req, {16'h0, sdo_data}, {16'h0, it.exp});
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [7:0] e);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, {24'h0, reg_rdata}, {24'h0, e});
  endtask

  task automatic strobe(input logic [15:0] x, input string req);
    sb_item_t it;
    @(negedge clk);
    fs_tick = 1'b1; sdi_data = x;
    hist.push_back(x);
    @(negedge clk);
    fs_tick = 1'b0;
    chk({req, " tx_valid"}, {31'h0, ls_tx_valid}, {31'h0, !m_pwr});
    if (!m_pwr) begin
      chk({req, " tx_data"}, {16'h0, ls_tx_data}, {16'h0, x});
      chk({req, " tx_mode"}, {30'h0, ls_tx_mode}, {30'h0, m_mode});
      if (partner_on) begin
        ls_rx_valid = 1'b1;
        ls_rx_data  = partner(x, m_mode);
        m_rx        = partner(x, m_mode);
      end
    end
    @(negedge clk);
    ls_rx_valid = 1'b0;
    it.req = req;
    it.exp = m_loop ? filt_exp() : m_rx;
    exp_q.push_back(it);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 pwr", 4'd6, 8'h10);
    rd("R1 hyb", 4'd2, 8'h02);
    rd("R1 dlb", 4'd1, 8'h00);
    rd("R1 hook", 4'd5, 8'h00);
    rd("R1 stat", 4'd12, 8'h00);
    chk("R1 tx_valid", {31'h0, ls_tx_valid}, 32'h0);

    // R2 power-down filter loop
    for (int i = 0; i < 7; i++) strobe(16'h1000 + 16'(i * 17), "R2");

    // R8 and R9 register behaviour
    rd("R8 rev host", 4'd11, 8'h04);
    rd("R8 rev line", 4'd13, 8'h01);
    wr(4'd11, 8'hFF);
    rd("R9 ro rev host", 4'd11, 8'h04);
    wr(4'd13, 8'hFF);
    rd("R9 ro rev line", 4'd13, 8'h01);
    wr(4'd12, 8'hFF);
    rd("R9 ro stat", 4'd12, 8'h00);
    wr(4'd1, 8'h01);
    rd("R9 dlb rb", 4'd1, 8'h01);
    wr(4'd1, 8'h00);
    rd("R9 dlb clr", 4'd1, 8'h00);

    // R3 and R4: power up line side
    wr(4'd6, 8'h00);
    m_pwr = 1'b0; m_loop = 1'b0;
    rd("R4 no link yet", 4'd12, 8'h00);
    strobe(16'hABCD, "R3 first frame");
    chk("R4 link rise", {31'h0, link_up}, 32'h1);
    rd("R4 stat link", 4'd12, 8'h40);
    strobe(16'h5A5A, "R3 second frame");

    // R4 link timeout
    partner_on = 0;
    strobe(16'h0101, "R3 hold 1");
    strobe(16'h0202, "R3 hold 2");
    chk("R4 link kept", {31'h0, link_up}, 32'h1);
    strobe(16'h0303, "R3 hold 3");
    chk("R4 link timeout", {31'h0, link_up}, 32'h0);
    partner_on = 1;
    strobe(16'h0404, "R3 resume");
    chk("R4 link back", {31'h0, link_up}, 32'h1);

    // R5 calibration window with digital loop held off
    wr(4'd5, 8'h01);
    chk("R5 busy high", {31'h0, cal_busy}, 32'h1);
    wr(4'd1, 8'h01);
    for (int i = 0; i < CL - 1; i++) strobe(16'(i * 3 + 7), "R5 held");
    chk("R5 busy at CAL_LEN-1", {31'h0, cal_busy}, 32'h1);
    rd("R5 stat busy", 4'd12, 8'h41);
    strobe(16'h7777, "R5 last");
    chk("R5 busy done", {31'h0, cal_busy}, 32'h0);

    // R6 mode codes
    m_mode = 2'd1;
    strobe(16'h2468, "R6 digital loop");
    wr(4'd1, 8'h00);
    wr(4'd2, 8'h03);
    m_mode = 2'd2;
    strobe(16'h1357, "R6 external loop");
    wr(4'd2, 8'h00);
    m_mode = 2'd3;
    strobe(16'h0F0F, "R6 internal loop");
    wr(4'd2, 8'h02);
    m_mode = 2'd0;
    strobe(16'h3C3C, "R6 none");

    // R7 conflicting modes
    wr(4'd2, 8'h03);
    wr(4'd1, 8'h01);
    chk("R7 err flag", {31'h0, mode_err}, 32'h1);
    rd("R7 stat err", 4'd12, 8'h42);
    m_loop = 1'b1; m_mode = 2'd0;
    strobe(16'h4444, "R7 fallback 1");
    strobe(16'h5555, "R7 fallback 2");
    wr(4'd1, 8'h00);
    chk("R7 err clear", {31'h0, mode_err}, 32'h0);
    m_loop = 1'b0; m_mode = 2'd2;
    strobe(16'h6666, "R7 recover");

    // R2 and R4 on power-down again
    wr(4'd6, 8'h10);
    m_pwr = 1'b1; m_loop = 1'b1;
    rd("R4 link drop", 4'd12, 8'h00);
    strobe(16'h9999, "R2 pd again 1");
    strobe(16'h8888, "R2 pd again 2");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule